// File: doc/BRIEF.md
# Vectored Interrupt Priority Core

This block keeps the per-vector state of a processor-side interrupt controller covering 256 vectors. It holds three bit arrays: requests waiting for service, vectors currently being serviced, and the trigger kind (level or edge) last seen for each vector. From these arrays it decides whether to raise an interrupt request toward the processor. It returns a vector when the processor acknowledges and retires the top in-service vector at end of interrupt.

Priority is judged by class, which is the upper four bits of the vector number. A pending vector interrupts only if its class is above the current processor priority. That priority is derived from the task priority and the top in-service vector. A software-enable bit and a spurious vector live together in one 9-bit setting. When an acknowledge cannot be honoured, the spurious vector is returned in place of a real one. An INIT pulse returns the arrays and the setting to their start values without a full reset.

Top module: `vec_prio_core`

## Requirements
- R1: After rst_ni, all three arrays are zero, the task priority is 0, the enable/spurious setting is 0x0FF (disabled, spurious 0xFF), irq_o is 0 and ppr_o is 0.
- R2: rd_data_o returns word rd_word_i of the array chosen by rd_sel_i (0 pending, 1 in-service, 2 trigger mode, 3 reads zero). Bit b of word w stands for vector 32*w+b. The read is combinational and reflects state after the last clock edge.
- R3: A set request with set_valid_i sets the pending bit of set_vec_i. The trigger bit of that vector becomes set_level_i (1 level, 0 edge). The change is visible after the next edge.
- R4: ppr_o equals the task priority when the task priority's class is at least the class of the top in-service vector, or when no vector is in service. Otherwise ppr_o is that vector's class with the low nibble zero.
- R5: irq_o is a register. It is 1 one edge after a state in which bit 8 of the enable setting is 1, a pending bit exists, and either ppr_o is zero or the top pending vector's class is strictly above ppr_o's class. Otherwise it is 0.
- R6: An acknowledge that is accepted moves the top pending vector from pending to in-service. ack_vec_o shows that vector after the edge that samples ack_i.
- R7: An acknowledge is refused when the block is disabled, when nothing is pending, or when the task priority is nonzero and the top pending vector is less than or equal to it. A refused acknowledge puts the low 8 bits of the enable setting on ack_vec_o and changes no array.
- R8: End of interrupt clears the highest set in-service bit. With no bit in service it changes nothing.
- R9: tpr_we_i loads all 8 task-priority bits. tpr_nib_we_i loads tpr_nib_i into bits 7:4 and zeroes bits 3:0.
- R10: init_i clears all three arrays and sets the enable setting to 0x0FF. The task priority is kept. init_i wins over every other request in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| set_valid_i | input | 1 | Raise a vector request |
| set_vec_i | input | 8 | Vector number to raise |
| set_level_i | input | 1 | Trigger kind of the request: 1 level, 0 edge |
| tpr_we_i | input | 1 | Load full task priority |
| tpr_data_i | input | 8 | Task priority value |
| tpr_nib_we_i | input | 1 | Load task priority class only |
| tpr_nib_i | input | 4 | Class value placed in bits 7:4 |
| svr_we_i | input | 1 | Load enable/spurious setting |
| svr_data_i | input | 9 | Bit 8 enable, bits 7:0 spurious vector |
| init_i | input | 1 | INIT reset pulse |
| ack_i | input | 1 | Processor acknowledge |
| eoi_i | input | 1 | End of interrupt |
| rd_sel_i | input | 2 | Array select for readback |
| rd_word_i | input | 3 | Word index for readback |
| rd_data_o | output | 32 | Readback word |
| ack_vec_o | output | 8 | Vector returned by the last acknowledge |
| irq_o | output | 1 | Interrupt request to the processor |
| ppr_o | output | 8 | Processor priority |

## Verification
Array contents, ppr_o and ack_vec_o follow from the clock edge that samples a request. The bench drives each request on a falling edge and reads these results on the next falling edge. irq_o passes through one more register, so it is read one falling edge later than that. Each scenario checks that one-edge lag explicitly, including the cases where the class comparison or the disable bit must hold the line low.

// File: rtl/vec_prio_pkg.sv
package vec_prio_pkg;
  localparam int unsigned NUM_VEC  = 256;
  localparam int unsigned VEC_W    = $clog2(NUM_VEC);
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned NUM_WORD = NUM_VEC / WORD_W;
  localparam int unsigned WSEL_W   = $clog2(NUM_WORD);

  typedef enum logic [1:0] {
    SEL_PEND = 2'd0,
    SEL_ISR  = 2'd1,
    SEL_TMR  = 2'd2,
    SEL_NONE = 2'd3
  } rd_sel_e;
endpackage

// File: rtl/vec_find_top.sv
module vec_find_top #(
  parameter int unsigned N = 256,
  parameter int unsigned W = $clog2(N)
) (
  input  logic [N-1:0] bits_i,
  output logic [W-1:0] idx_o,
  output logic         valid_o
);
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (bits_i[i]) idx_o = W'(i);
    end
  end
  assign valid_o = |bits_i;
endmodule

// File: rtl/vec_ppr_calc.sv
module vec_ppr_calc #(
  parameter int unsigned VW = 8
) (
  input  logic [VW-1:0] tpr_i,
  input  logic [VW-1:0] isr_top_i,
  input  logic          isr_valid_i,
  output logic [VW-1:0] ppr_o
);
  logic [3:0] isr_cls;
  assign isr_cls = isr_valid_i ? isr_top_i[VW-1 -: 4] : 4'd0;

  always_comb begin
    if (tpr_i[VW-1 -: 4] >= isr_cls) ppr_o = tpr_i;
    else                             ppr_o = {isr_cls, {(VW-4){1'b0}}};
  end
endmodule

// File: rtl/vec_prio_core.sv
module vec_prio_core
  import vec_prio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_valid_i,
  input  logic [VEC_W-1:0]  set_vec_i,
  input  logic              set_level_i,
  input  logic              tpr_we_i,
  input  logic [VEC_W-1:0]  tpr_data_i,
  input  logic              tpr_nib_we_i,
  input  logic [3:0]        tpr_nib_i,
  input  logic              svr_we_i,
  input  logic [VEC_W:0]    svr_data_i,
  input  logic              init_i,
  input  logic              ack_i,
  input  logic              eoi_i,
  input  logic [1:0]        rd_sel_i,
  input  logic [WSEL_W-1:0] rd_word_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic [VEC_W-1:0]  ack_vec_o,
  output logic              irq_o,
  output logic [VEC_W-1:0]  ppr_o
);
  localparam logic [VEC_W:0] SVR_INIT = {1'b0, {VEC_W{1'b1}}};

  logic [NUM_VEC-1:0] pend_q, isr_q, tmr_q;
  logic [NUM_VEC-1:0] pend_n, isr_n, tmr_n;
  logic [VEC_W-1:0]   tpr_q, ack_vec_q;
  logic [VEC_W:0]     svr_q;
  logic               irq_q;

  logic [VEC_W-1:0]   pend_idx, isr_idx;
  logic               pend_vld, isr_vld;
  logic               enabled, take, irq_d;

  vec_find_top #(.N(NUM_VEC), .W(VEC_W)) u_pend_top (
    .bits_i(pend_q), .idx_o(pend_idx), .valid_o(pend_vld));

  vec_find_top #(.N(NUM_VEC), .W(VEC_W)) u_isr_top (
    .bits_i(isr_q), .idx_o(isr_idx), .valid_o(isr_vld));

  vec_ppr_calc #(.VW(VEC_W)) u_ppr (
    .tpr_i(tpr_q), .isr_top_i(isr_idx), .isr_valid_i(isr_vld), .ppr_o(ppr_o));

  assign enabled = svr_q[VEC_W];
  assign take    = ack_i && enabled && pend_vld &&
                   !((tpr_q != '0) && (pend_idx <= tpr_q));
  assign irq_d   = enabled && pend_vld &&
                   ((ppr_o == '0) || (pend_idx[VEC_W-1 -: 4] > ppr_o[VEC_W-1 -: 4]));

  // ack clears before set applies; eoi uses current in-service top
  always_comb begin
    pend_n = pend_q;
    isr_n  = isr_q;
    tmr_n  = tmr_q;
    if (take) begin
      pend_n[pend_idx] = 1'b0;
    end
    if (eoi_i && isr_vld) isr_n[isr_idx] = 1'b0;
    if (take) isr_n[pend_idx] = 1'b1;
    if (set_valid_i) begin
      pend_n[set_vec_i] = 1'b1;
      tmr_n[set_vec_i]  = set_level_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q    <= '0;
      isr_q     <= '0;
      tmr_q     <= '0;
      svr_q     <= SVR_INIT;
      tpr_q     <= '0;
      ack_vec_q <= '0;
      irq_q     <= 1'b0;
    end else if (init_i) begin
      pend_q <= '0;
      isr_q  <= '0;
      tmr_q  <= '0;
      svr_q  <= SVR_INIT;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_n;
      isr_q  <= isr_n;
      tmr_q  <= tmr_n;
      irq_q  <= irq_d;
      if (svr_we_i) svr_q <= svr_data_i;
      if (tpr_we_i)          tpr_q <= tpr_data_i;
      else if (tpr_nib_we_i) tpr_q <= {tpr_nib_i, {(VEC_W-4){1'b0}}};
      if (ack_i) ack_vec_q <= take ? pend_idx : svr_q[VEC_W-1:0];
    end
  end

  always_comb begin
    unique case (rd_sel_e'(rd_sel_i))
      SEL_PEND: rd_data_o = pend_q[rd_word_i*WORD_W +: WORD_W];
      SEL_ISR:  rd_data_o = isr_q[rd_word_i*WORD_W +: WORD_W];
      SEL_TMR:  rd_data_o = tmr_q[rd_word_i*WORD_W +: WORD_W];
      default:  rd_data_o = '0;
    endcase
  end

  assign ack_vec_o = ack_vec_q;
  assign irq_o     = irq_q;

  a_r5_disabled_no_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !svr_q[VEC_W] |=> !irq_o);
  a_r3_set_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_valid_i && !init_i) |=> pend_q[$past(set_vec_i)]);
  a_r6_ack_in_service: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && !init_i) |=> (isr_q[$past(pend_idx)] && ack_vec_o == $past(pend_idx)));
  a_r8_eoi_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && isr_vld && !take && !init_i) |=> !isr_q[$past(isr_idx)]);
  a_r10_init_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> (pend_q == '0 && isr_q == '0 && tmr_q == '0 && svr_q == SVR_INIT && !irq_o));
  a_r4_ppr_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ppr_o[VEC_W-1 -: 4] >= tpr_q[VEC_W-1 -: 4]);
endmodule

// File: tb/vec_prio_core_bench.sv
module vec_prio_core_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        set_valid = 0, set_level = 0, tpr_we = 0, tpr_nib_we = 0;
  logic        svr_we = 0, init = 0, ack = 0, eoi = 0;
  logic [7:0]  set_vec = 0, tpr_data = 0;
  logic [3:0]  tpr_nib = 0;
  logic [8:0]  svr_data = 0;
  logic [1:0]  rd_sel = 0;
  logic [2:0]  rd_word = 0;
  logic [31:0] rd_data;
  logic [7:0]  ack_vec, ppr;
  logic        irq;
  int          errors = 0, checks = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  vec_prio_core u_vec_prio_core (
    .clk_i(clk), .rst_ni(rst_n),
    .set_valid_i(set_valid), .set_vec_i(set_vec), .set_level_i(set_level),
    .tpr_we_i(tpr_we), .tpr_data_i(tpr_data),
    .tpr_nib_we_i(tpr_nib_we), .tpr_nib_i(tpr_nib),
    .svr_we_i(svr_we), .svr_data_i(svr_data), .init_i(init),
    .ack_i(ack), .eoi_i(eoi), .rd_sel_i(rd_sel), .rd_word_i(rd_word),
    .rd_data_o(rd_data), .ack_vec_o(ack_vec), .irq_o(irq), .ppr_o(ppr));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic rd_chk(string req, logic [1:0] s, logic [2:0] w, logic [31:0] exp);
    rd_sel = s; rd_word = w; #1;
    chk(req, rd_data, exp);
  endtask

  task automatic do_set(logic [7:0] v, logic lvl);
    set_valid = 1; set_vec = v; set_level = lvl; step(); set_valid = 0;
  endtask
  task automatic do_svr(logic [8:0] d);
    svr_we = 1; svr_data = d; step(); svr_we = 0;
  endtask
  task automatic do_tpr(logic [7:0] d);
    tpr_we = 1; tpr_data = d; step(); tpr_we = 0;
  endtask
  task automatic do_ack();
    ack = 1; step(); ack = 0;
  endtask
  task automatic do_eoi();
    eoi = 1; step(); eoi = 0;
  endtask
  task automatic do_init();
    init = 1; step(); init = 0;
  endtask

  task automatic t_reset();
    chk("R1 irq", irq, 0);
    chk("R1 ppr", ppr, 0);
    for (int w = 0; w < 8; w++) rd_chk("R1 pend", 0, 3'(w), 0);
    rd_chk("R1 isr", 1, 7, 0);
    do_ack();
    chk("R1 spurious FF", ack_vec, 8'hFF);
  endtask

  task automatic t_set_trigger();
    do_init(); do_svr(9'h10F);
    do_set(8'h45, 1);
    rd_chk("R3 pend", 0, 2, 32'h20);
    rd_chk("R3 level tmr", 2, 2, 32'h20);
    chk("R5 irq lag", irq, 0);
    step();
    chk("R5 irq up", irq, 1);
    do_set(8'h45, 0);
    rd_chk("R3 edge tmr", 2, 2, 0);
    do_set(8'hFF, 0);
    rd_chk("R2 word7", 0, 7, 32'h8000_0000);
    rd_chk("R2 sel3 zero", 3, 7, 0);
  endtask

  task automatic t_disabled();
    do_init();
    do_set(8'h30, 0);
    step(); step();
    chk("R5 disabled irq", irq, 0);
    do_ack();
    chk("R7 disabled spurious", ack_vec, 8'hFF);
    rd_chk("R7 pend kept", 0, 1, 32'h0001_0000);
    rd_chk("R7 isr empty", 1, 1, 0);
  endtask

  task automatic t_ack_eoi();
    do_init(); do_svr(9'h10F);
    do_set(8'h45, 0); do_set(8'h92, 0);
    do_ack();
    chk("R6 top vector", ack_vec, 8'h92);
    rd_chk("R6 isr", 1, 4, 32'h0004_0000);
    rd_chk("R6 pend cleared", 0, 4, 0);
    chk("R4 ppr from isr", ppr, 8'h90);
    step(); step();
    chk("R5 class blocks", irq, 0);
    do_set(8'hA3, 0);
    step();
    chk("R5 higher class", irq, 1);
    do_eoi();
    rd_chk("R8 eoi top", 1, 4, 0);
    chk("R4 ppr empty isr", ppr, 0);
    do_eoi();
    rd_chk("R8 eoi empty pend", 0, 5, 32'h0000_0008);
    do_init(); do_svr(9'h10F);
    do_set(8'h00, 0);
    step();
    chk("R5 vector0 ppr0", irq, 1);
  endtask

  task automatic t_tpr();
    do_init(); do_svr(9'h10F);
    do_tpr(8'h50);
    chk("R9 ppr tpr", ppr, 8'h50);
    do_set(8'h50, 0);
    step();
    chk("R5 equal class", irq, 0);
    do_ack();
    chk("R7 at tpr spurious", ack_vec, 8'h0F);
    rd_chk("R7 pend kept", 0, 2, 32'h0001_0000);
    do_set(8'h61, 0);
    step();
    chk("R5 above tpr", irq, 1);
    do_ack();
    chk("R6 ack above tpr", ack_vec, 8'h61);
    tpr_nib_we = 1; tpr_nib = 4'h7; step(); tpr_nib_we = 0;
    chk("R9 nibble", ppr, 8'h70);
    do_tpr(8'h2C);
    chk("R4 isr class wins", ppr, 8'h60);
  endtask

  task automatic t_init();
    do_svr(9'h1AA);
    do_set(8'h80, 1);
    init = 1; set_valid = 1; set_vec = 8'h81; step(); init = 0; set_valid = 0;
    rd_chk("R10 pend", 0, 4, 0);
    rd_chk("R10 tmr", 2, 4, 0);
    rd_chk("R10 isr", 1, 3, 0);
    chk("R10 tpr kept", ppr, 8'h2C);
    step();
    chk("R10 irq", irq, 0);
    do_ack();
    chk("R10 svr FF", ack_vec, 8'hFF);
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1;
    step();
    t_reset();
    t_set_trigger();
    t_disabled();
    t_ack_eoi();
    t_tpr();
    t_init();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule